// File: doc/BRIEF.md
# Temperature Sensor Scan Sequencer

The block schedules the read-out of a bank of temperature sensors that share one analog multiplexer and one 16-bit ADC. Each sensor is described in a local table by its kind (precision thermistor or diode), the index of its excitation current level and its amplifier gain code. For each reading the sequencer sets the multiplexer address, picks the current source that matches the sensor kind, and applies the level and gain from the table. It then waits a programmable settling time, pulses the ADC start line and waits for the ADC done line. The returned sample is written into a result file.

A one-second tick starts a scan cycle. Every thermistor is read in ascending index order. After that, a small rotating slice of the diode sensors is read, continuing from where the previous cycle stopped, so the whole diode population is covered over several cycles. Each thermistor result is also sent on an update strobe that feeds downstream control loops. After every tenth completed cycle the whole result file is streamed out as a housekeeping snapshot. A tick that arrives while a cycle is still running is dropped and recorded in a sticky overrun flag.

Top module: `tscan_seq`

## Requirements
- R1: While reset is held, busy_o, adc_start_o, upd_valid_o, hk_valid_o and overrun_o are 0 and mux_addr_o is 0.
- R2: A tick_i pulse seen while idle starts a cycle in which every sensor whose table kind is thermistor (kind bit 0) is converted exactly once, in ascending index order.
- R3: After the thermistors, the cycle searches round-robin for diode sensors (kind bit 1), starting at a diode pointer that is 0 after reset. It converts up to DIODES_PER_TICK of them and inspects at most N_SNS table entries. The pointer then moves to the entry after the last one inspected, so no diode is read twice in one cycle.
- R4: During a conversion, mux_addr_o equals the sensor index, src_sel_o equals its kind bit, and cur_lvl_o and gain_o equal its table entries. All four stay stable from the start pulse until done.
- R5: adc_start_o is raised no earlier than settle_i+1 clock cycles after the last change of the drive outputs and after the last adc_done_i.
- R6: adc_start_o is a one-cycle pulse, and no new start is issued while a conversion is outstanding.
- R7: One cycle after adc_done_i closes a thermistor conversion, upd_valid_o pulses for one cycle with upd_idx_o equal to the sensor index and upd_data_o equal to the sample. Diode conversions produce no update pulse.
- R8: After every HK_PERIOD-th completed cycle (10 by default), hk_valid_o is high for N_SNS consecutive cycles. hk_idx_o runs from 0 upward and hk_data_o carries the latest stored sample of that sensor, or 0 if the sensor has never been read.
- R9: A tick_i arriving while busy causes no extra conversion and sets overrun_o, which stays set until reset.
- R10: busy_o goes high on the cycle after an accepted tick and stays high until the cycle, including any housekeeping stream, has ended. No start is issued while busy_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second cycle start pulse |
| settle_i | input | SETTLE_W | Settling delay in clock cycles |
| cfg_we_i | input | 1 | Sensor table write enable |
| cfg_idx_i | input | IDX_W | Sensor table write index |
| cfg_diode_i | input | 1 | Sensor kind: 0 thermistor, 1 diode |
| cfg_lvl_i | input | 3 | Excitation current level index |
| cfg_gain_i | input | 2 | Amplifier gain code |
| adc_done_i | input | 1 | ADC conversion complete |
| adc_data_i | input | ADC_W | ADC sample, valid with adc_done_i |
| adc_start_o | output | 1 | ADC conversion start pulse |
| mux_addr_o | output | IDX_W | Analog multiplexer address |
| src_sel_o | output | 1 | Current source select: 0 thermistor, 1 diode |
| cur_lvl_o | output | 3 | Current level index |
| gain_o | output | 2 | Amplifier gain code |
| upd_valid_o | output | 1 | Thermistor update strobe |
| upd_idx_o | output | IDX_W | Sensor index of the update |
| upd_data_o | output | ADC_W | Sample of the update |
| hk_valid_o | output | 1 | Housekeeping stream valid |
| hk_idx_o | output | IDX_W | Housekeeping sensor index |
| hk_data_o | output | ADC_W | Housekeeping stored sample |
| busy_o | output | 1 | Cycle in progress |
| overrun_o | output | 1 | Sticky tick overrun flag |

## Verification
The bench targets three things: diode pointer wrap-around, tables with no diodes, only diodes or a single diode, and the settle bound at zero and at a long delay. A wrong pointer would repeat or skip diodes, or convert one diode twice in a cycle. A wrong settle count would fire the ADC before the excitation has stabilised. It also sends a tick in the middle of a cycle, where a faulty design would restart the scan or clear the flag. It checks the tenth-cycle snapshot, where an off-by-one counter would send the frame a cycle early or late, or send stale values. Update strobes are checked both for presence and for absence, so a strobe sent for a diode reading is reported.

// File: rtl/tscan_pkg.sv
package tscan_pkg;
  localparam int LVL_W  = 3;
  localparam int GAIN_W = 2;

  typedef enum logic {
    SNS_THERM = 1'b0,
    SNS_DIODE = 1'b1
  } sns_kind_e;

  typedef struct packed {
    sns_kind_e          kind;
    logic [LVL_W-1:0]   lvl;
    logic [GAIN_W-1:0]  gain;
  } sns_cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_SETTLE,
    ST_START,
    ST_WAIT,
    ST_HK
  } seq_state_e;
endpackage

// File: rtl/tscan_cfg_tab.sv
module tscan_cfg_tab import tscan_pkg::*; #(
  parameter int N_SNS = 46,
  localparam int IDX_W = $clog2(N_SNS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  sns_cfg_t         wr_cfg_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output sns_cfg_t         rd_cfg_o
);
  sns_cfg_t tab_q [N_SNS];

  for (genvar g = 0; g < N_SNS; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tab_q[g] <= '0;
      else if (we_i && wr_idx_i == IDX_W'(g)) tab_q[g] <= wr_cfg_i;
    end
  end

  assign rd_cfg_o = (int'(rd_idx_i) < N_SNS) ? tab_q[rd_idx_i] : '0;
endmodule

// File: rtl/tscan_res_file.sv
module tscan_res_file #(
  parameter int N_SNS = 46,
  parameter int ADC_W = 16,
  localparam int IDX_W = $clog2(N_SNS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [ADC_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [ADC_W-1:0] rd_data_o
);
  logic [ADC_W-1:0] mem_q [N_SNS];

  for (genvar g = 0; g < N_SNS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= '0;
      else if (we_i && wr_idx_i == IDX_W'(g)) mem_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o = (int'(rd_idx_i) < N_SNS) ? mem_q[rd_idx_i] : '0;
endmodule

// File: rtl/tscan_fsm.sv
module tscan_fsm import tscan_pkg::*; #(
  parameter int N_SNS           = 46,
  parameter int ADC_W           = 16,
  parameter int SETTLE_W        = 8,
  parameter int DIODES_PER_TICK = 2,
  parameter int HK_PERIOD       = 10,
  localparam int IDX_W = $clog2(N_SNS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  sns_cfg_t            cfg_i,
  output logic [IDX_W-1:0]    idx_o,
  input  logic                adc_done_i,
  input  logic [ADC_W-1:0]    adc_data_i,
  output logic                adc_start_o,
  output logic                res_we_o,
  output logic [IDX_W-1:0]    hk_ridx_o,
  input  logic [ADC_W-1:0]    hk_rdata_i,
  output logic [IDX_W-1:0]    mux_addr_o,
  output logic                src_sel_o,
  output logic [LVL_W-1:0]    cur_lvl_o,
  output logic [GAIN_W-1:0]   gain_o,
  output logic                upd_valid_o,
  output logic [IDX_W-1:0]    upd_idx_o,
  output logic [ADC_W-1:0]    upd_data_o,
  output logic                hk_valid_o,
  output logic [IDX_W-1:0]    hk_idx_o,
  output logic [ADC_W-1:0]    hk_data_o,
  output logic                busy_o,
  output logic                overrun_o
);
  localparam int SC_W = $clog2(N_SNS + 1);
  localparam int DC_W = $clog2(DIODES_PER_TICK + 1);
  localparam int HC_W = $clog2(HK_PERIOD);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_SNS - 1);

  seq_state_e          state_q;
  logic                therm_q;
  logic [IDX_W-1:0]    idx_q, dptr_q, hk_ptr_q;
  logic [SC_W-1:0]     scan_q;
  logic [DC_W-1:0]     dcnt_q;
  logic [SETTLE_W-1:0] scnt_q;
  logic [HC_W-1:0]     cyc_q;

  logic [IDX_W-1:0] idx_inc, nx_idx;
  logic [SC_W-1:0]  nx_scan;
  logic             nx_therm, nx_clr, diode_end, want;

  // step to the next table entry; thermistor pass hands over to the diode pass
  always_comb begin
    idx_inc  = (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
    nx_therm = therm_q;
    nx_idx   = idx_inc;
    nx_scan  = scan_q;
    nx_clr   = 1'b0;
    if (therm_q) begin
      if (idx_q == LAST_IDX) begin
        nx_therm = 1'b0;
        nx_idx   = dptr_q;
        nx_scan  = '0;
        nx_clr   = 1'b1;
      end
    end else begin
      nx_scan = scan_q + 1'b1;
    end
  end

  assign diode_end = (dcnt_q == DC_W'(DIODES_PER_TICK)) || (scan_q == SC_W'(N_SNS));
  assign want      = therm_q ? (cfg_i.kind == SNS_THERM) : (cfg_i.kind == SNS_DIODE);

  assign idx_o       = idx_q;
  assign hk_ridx_o   = hk_ptr_q;
  assign adc_start_o = (state_q == ST_START);
  assign res_we_o    = (state_q == ST_WAIT) && adc_done_i;
  assign busy_o      = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      therm_q     <= 1'b1;
      idx_q       <= '0;
      dptr_q      <= '0;
      hk_ptr_q    <= '0;
      scan_q      <= '0;
      dcnt_q      <= '0;
      scnt_q      <= '0;
      cyc_q       <= '0;
      mux_addr_o  <= '0;
      src_sel_o   <= 1'b0;
      cur_lvl_o   <= '0;
      gain_o      <= '0;
      upd_valid_o <= 1'b0;
      upd_idx_o   <= '0;
      upd_data_o  <= '0;
      hk_valid_o  <= 1'b0;
      hk_idx_o    <= '0;
      hk_data_o   <= '0;
      overrun_o   <= 1'b0;
    end else begin
      upd_valid_o <= 1'b0;
      hk_valid_o  <= 1'b0;
      if (tick_i && state_q != ST_IDLE) overrun_o <= 1'b1;

      unique case (state_q)
        ST_IDLE: begin
          if (tick_i) begin
            therm_q <= 1'b1;
            idx_q   <= '0;
            state_q <= ST_SEL;
          end
        end
        ST_SEL: begin
          if (!therm_q && diode_end) begin
            dptr_q <= idx_q;
            if (cyc_q == HC_W'(HK_PERIOD - 1)) begin
              cyc_q    <= '0;
              hk_ptr_q <= '0;
              state_q  <= ST_HK;
            end else begin
              cyc_q   <= cyc_q + 1'b1;
              state_q <= ST_IDLE;
            end
          end else if (want) begin
            mux_addr_o <= idx_q;
            src_sel_o  <= cfg_i.kind;
            cur_lvl_o  <= cfg_i.lvl;
            gain_o     <= cfg_i.gain;
            scnt_q     <= '0;
            state_q    <= ST_SETTLE;
          end else begin
            therm_q <= nx_therm;
            idx_q   <= nx_idx;
            scan_q  <= nx_scan;
            if (nx_clr) dcnt_q <= '0;
          end
        end
        ST_SETTLE: begin
          if (scnt_q == settle_i) state_q <= ST_START;
          else                    scnt_q  <= scnt_q + 1'b1;
        end
        ST_START: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (adc_done_i) begin
            if (therm_q) begin
              upd_valid_o <= 1'b1;
              upd_idx_o   <= idx_q;
              upd_data_o  <= adc_data_i;
            end
            therm_q <= nx_therm;
            idx_q   <= nx_idx;
            scan_q  <= nx_scan;
            if (nx_clr)        dcnt_q <= '0;
            else if (!therm_q) dcnt_q <= dcnt_q + 1'b1;
            state_q <= ST_SEL;
          end
        end
        ST_HK: begin
          hk_valid_o <= 1'b1;
          hk_idx_o   <= hk_ptr_q;
          hk_data_o  <= hk_rdata_i;
          if (hk_ptr_q == LAST_IDX) state_q  <= ST_IDLE;
          else                      hk_ptr_q <= hk_ptr_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tscan_seq.sv
module tscan_seq import tscan_pkg::*; #(
  parameter int N_SNS           = 46,
  parameter int ADC_W           = 16,
  parameter int SETTLE_W        = 8,
  parameter int DIODES_PER_TICK = 2,
  parameter int HK_PERIOD       = 10,
  localparam int IDX_W = $clog2(N_SNS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic                cfg_we_i,
  input  logic [IDX_W-1:0]    cfg_idx_i,
  input  logic                cfg_diode_i,
  input  logic [LVL_W-1:0]    cfg_lvl_i,
  input  logic [GAIN_W-1:0]   cfg_gain_i,
  input  logic                adc_done_i,
  input  logic [ADC_W-1:0]    adc_data_i,
  output logic                adc_start_o,
  output logic [IDX_W-1:0]    mux_addr_o,
  output logic                src_sel_o,
  output logic [LVL_W-1:0]    cur_lvl_o,
  output logic [GAIN_W-1:0]   gain_o,
  output logic                upd_valid_o,
  output logic [IDX_W-1:0]    upd_idx_o,
  output logic [ADC_W-1:0]    upd_data_o,
  output logic                hk_valid_o,
  output logic [IDX_W-1:0]    hk_idx_o,
  output logic [ADC_W-1:0]    hk_data_o,
  output logic                busy_o,
  output logic                overrun_o
);
  sns_cfg_t         wr_cfg, rd_cfg;
  logic [IDX_W-1:0] seq_idx, hk_ridx;
  logic [ADC_W-1:0] hk_rdata;
  logic             res_we;

  assign wr_cfg = '{kind: sns_kind_e'(cfg_diode_i), lvl: cfg_lvl_i, gain: cfg_gain_i};

  tscan_cfg_tab #(.N_SNS(N_SNS)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .wr_idx_i (cfg_idx_i),
    .wr_cfg_i (wr_cfg),
    .rd_idx_i (seq_idx),
    .rd_cfg_o (rd_cfg)
  );

  tscan_res_file #(.N_SNS(N_SNS), .ADC_W(ADC_W)) u_res (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (res_we),
    .wr_idx_i  (seq_idx),
    .wr_data_i (adc_data_i),
    .rd_idx_i  (hk_ridx),
    .rd_data_o (hk_rdata)
  );

  tscan_fsm #(
    .N_SNS(N_SNS), .ADC_W(ADC_W), .SETTLE_W(SETTLE_W),
    .DIODES_PER_TICK(DIODES_PER_TICK), .HK_PERIOD(HK_PERIOD)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .settle_i    (settle_i),
    .cfg_i       (rd_cfg),
    .idx_o       (seq_idx),
    .adc_done_i  (adc_done_i),
    .adc_data_i  (adc_data_i),
    .adc_start_o (adc_start_o),
    .res_we_o    (res_we),
    .hk_ridx_o   (hk_ridx),
    .hk_rdata_i  (hk_rdata),
    .mux_addr_o  (mux_addr_o),
    .src_sel_o   (src_sel_o),
    .cur_lvl_o   (cur_lvl_o),
    .gain_o      (gain_o),
    .upd_valid_o (upd_valid_o),
    .upd_idx_o   (upd_idx_o),
    .upd_data_o  (upd_data_o),
    .hk_valid_o  (hk_valid_o),
    .hk_idx_o    (hk_idx_o),
    .hk_data_o   (hk_data_o),
    .busy_o      (busy_o),
    .overrun_o   (overrun_o)
  );
endmodule

// File: rtl/tscan_seq_chk.sv
module tscan_seq_chk import tscan_pkg::*; #(
  parameter int N_SNS           = 46,
  parameter int SETTLE_W        = 8,
  parameter int DIODES_PER_TICK = 2,
  localparam int IDX_W = $clog2(N_SNS)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                tick_i,
  input logic [SETTLE_W-1:0] settle_i,
  input logic                adc_done_i,
  input logic                adc_start_o,
  input logic [IDX_W-1:0]    mux_addr_o,
  input logic                src_sel_o,
  input logic [LVL_W-1:0]    cur_lvl_o,
  input logic [GAIN_W-1:0]   gain_o,
  input logic                upd_valid_o,
  input logic                hk_valid_o,
  input logic [IDX_W-1:0]    hk_idx_o,
  input logic                busy_o,
  input logic                overrun_o
);
  localparam int DQ_W = $clog2(DIODES_PER_TICK + 2);

  logic [SETTLE_W:0]  since_q;
  logic [IDX_W-1:0]   mux_q;
  logic [LVL_W-1:0]   lvl_q;
  logic [GAIN_W-1:0]  gain_q;
  logic               pend_q;
  logic [DQ_W-1:0]    dstart_q;
  logic               chg;

  assign chg = (mux_addr_o != mux_q) || (cur_lvl_o != lvl_q) || (gain_o != gain_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q  <= '0;
      mux_q    <= '0;
      lvl_q    <= '0;
      gain_q   <= '0;
      pend_q   <= 1'b0;
      dstart_q <= '0;
    end else begin
      mux_q  <= mux_addr_o;
      lvl_q  <= cur_lvl_o;
      gain_q <= gain_o;
      if (chg || adc_done_i) since_q <= (SETTLE_W+1)'(1);
      else if (since_q != '1) since_q <= since_q + 1'b1;
      if (adc_start_o)     pend_q <= 1'b1;
      else if (adc_done_i) pend_q <= 1'b0;
      if (tick_i && !busy_o) dstart_q <= '0;
      else if (adc_start_o && src_sel_o && dstart_q != '1) dstart_q <= dstart_q + 1'b1;
    end
  end

  a_r5_settle_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |-> since_q >= ((SETTLE_W+1)'(settle_i) + 1'b1));

  a_r6_start_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |=> !adc_start_o);

  a_r6_single_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |-> !pend_q);

  a_r4_drive_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> ($stable(mux_addr_o) && $stable(cur_lvl_o) && $stable(gain_o) && $stable(src_sel_o)));

  a_r7_upd_after_therm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_o |-> ($past(adc_done_i) && !src_sel_o));

  a_r3_diode_quota: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adc_start_o && src_sel_o) |-> (dstart_q < DQ_W'(DIODES_PER_TICK)));

  a_r8_hk_ascending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hk_valid_o && $past(hk_valid_o)) |-> (hk_idx_o == $past(hk_idx_o) + 1'b1));

  a_r9_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);

  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !adc_start_o);
endmodule

bind tscan_seq tscan_seq_chk #(
  .N_SNS(N_SNS), .SETTLE_W(SETTLE_W), .DIODES_PER_TICK(DIODES_PER_TICK)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .settle_i    (settle_i),
  .adc_done_i  (adc_done_i),
  .adc_start_o (adc_start_o),
  .mux_addr_o  (mux_addr_o),
  .src_sel_o   (src_sel_o),
  .cur_lvl_o   (cur_lvl_o),
  .gain_o      (gain_o),
  .upd_valid_o (upd_valid_o),
  .hk_valid_o  (hk_valid_o),
  .hk_idx_o    (hk_idx_o),
  .busy_o      (busy_o),
  .overrun_o   (overrun_o)
);

// File: tb/tscan_seq_bench.sv
`timescale 1ns/1ps
module tscan_seq_bench;
  localparam int N   = 46;
  localparam int K   = 2;
  localparam int HKP = 10;
  localparam int SW  = 8;
  localparam int IW  = 6;
  localparam int DW  = 16;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          tick_i = 1'b0;
  logic [SW-1:0] settle_i = 8'd3;
  logic          cfg_we_i = 1'b0;
  logic [IW-1:0] cfg_idx_i = '0;
  logic          cfg_diode_i = 1'b0;
  logic [2:0]    cfg_lvl_i = '0;
  logic [1:0]    cfg_gain_i = '0;
  logic          adc_done_i = 1'b0;
  logic [DW-1:0] adc_data_i = '0;
  logic          adc_start_o, src_sel_o, upd_valid_o, hk_valid_o, busy_o, overrun_o;
  logic [IW-1:0] mux_addr_o, upd_idx_o, hk_idx_o;
  logic [2:0]    cur_lvl_o;
  logic [1:0]    gain_o;
  logic [DW-1:0] upd_data_o, hk_data_o;

  always #2.5 clk = ~clk;

  tscan_seq u_tscan_seq (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .settle_i(settle_i),
    .cfg_we_i(cfg_we_i), .cfg_idx_i(cfg_idx_i), .cfg_diode_i(cfg_diode_i),
    .cfg_lvl_i(cfg_lvl_i), .cfg_gain_i(cfg_gain_i),
    .adc_done_i(adc_done_i), .adc_data_i(adc_data_i), .adc_start_o(adc_start_o),
    .mux_addr_o(mux_addr_o), .src_sel_o(src_sel_o), .cur_lvl_o(cur_lvl_o), .gain_o(gain_o),
    .upd_valid_o(upd_valid_o), .upd_idx_o(upd_idx_o), .upd_data_o(upd_data_o),
    .hk_valid_o(hk_valid_o), .hk_idx_o(hk_idx_o), .hk_data_o(hk_data_o),
    .busy_o(busy_o), .overrun_o(overrun_o)
  );

  int checks = 0;
  int errors = 0;
  bit          m_diode [N];
  logic [2:0]  m_lvl   [N];
  logic [1:0]  m_gain  [N];
  logic [15:0] m_res   [N];
  int m_dptr = 0, m_cyc = 0;
  int exp_idx [64];
  int exp_n = 0, exp_pos = 0, hk_cnt = 0, conv_seq = 0;
  bit upd_exp = 1'b0;
  int upd_idx_e = 0;
  logic [15:0] upd_data_e = '0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] f_val(input int seq, input int m, input int l, input int g);
    return 16'((m * 977 + l * 131 + g * 17 + seq * 2749 + 12345) & 32'hFFFF);
  endfunction

  task automatic cfg_wr(input int k, input bit d, input int l, input int g);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_idx_i = IW'(k); cfg_diode_i = d;
    cfg_lvl_i = 3'(l); cfg_gain_i = 2'(g);
    @(negedge clk);
    cfg_we_i = 1'b0;
    m_diode[k] = d; m_lvl[k] = 3'(l); m_gain[k] = 2'(g);
  endtask

  task automatic cfg_random(input int pct_diode);
    for (int k = 0; k < N; k++)
      cfg_wr(k, (int'($urandom % 100) < pct_diode), int'($urandom % 6), int'($urandom % 4));
  endtask

  task automatic run_cycle(input bit dbl);
    int i, s, c;
    exp_n = 0; exp_pos = 0; hk_cnt = 0;
    for (int k = 0; k < N; k++) if (!m_diode[k]) begin exp_idx[exp_n] = k; exp_n++; end
    i = m_dptr; s = 0; c = 0;
    while (c < K && s < N) begin
      if (m_diode[i]) begin exp_idx[exp_n] = i; exp_n++; c++; end
      i = (i + 1) % N; s++;
    end
    m_dptr = i;
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
    chk(busy_o == 1'b1, "R10", "busy after tick", int'(busy_o), 1);
    if (dbl) begin
      repeat (3) @(negedge clk);
      tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
    end
    while (busy_o) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(exp_pos == exp_n, "R2", "conversions in cycle", exp_pos, exp_n);
    m_cyc++;
    if (m_cyc == HKP) begin
      m_cyc = 0;
      chk(hk_cnt == N, "R8", "snapshot length", hk_cnt, N);
    end else begin
      chk(hk_cnt == 0, "R8", "no snapshot", hk_cnt, 0);
    end
  endtask

  // ADC model and output monitor
  initial begin : mon
    int prv_m, prv_l, prv_g, scnt, lat, cur, e;
    bit done_prev;
    logic [15:0] val;
    prv_m = 0; prv_l = 0; prv_g = 0; scnt = 0; lat = 0; cur = 0; e = 0;
    done_prev = 1'b0; val = '0;
    forever begin
      @(negedge clk);
      if (rst_ni) begin
        if (upd_exp || upd_valid_o) begin
          chk(upd_valid_o == upd_exp, "R7", "update strobe", int'(upd_valid_o), int'(upd_exp));
          if (upd_exp && upd_valid_o) begin
            chk(int'(upd_idx_o) == upd_idx_e, "R7", "update index", int'(upd_idx_o), upd_idx_e);
            chk(upd_data_o == upd_data_e, "R7", "update data", int'(upd_data_o), int'(upd_data_e));
          end
        end
        upd_exp = 1'b0;
        if (hk_valid_o) begin
          chk(int'(hk_idx_o) == hk_cnt, "R8", "snapshot index", int'(hk_idx_o), hk_cnt);
          if (hk_cnt < N)
            chk(hk_data_o == m_res[hk_cnt], "R8", "snapshot data", int'(hk_data_o), int'(m_res[hk_cnt]));
          hk_cnt++;
        end
        if (done_prev || int'(mux_addr_o) != prv_m || int'(cur_lvl_o) != prv_l || int'(gain_o) != prv_g)
          scnt = 0;
        else
          scnt++;
        prv_m = int'(mux_addr_o); prv_l = int'(cur_lvl_o); prv_g = int'(gain_o);
        done_prev = 1'b0;
        adc_done_i = 1'b0;
        if (adc_start_o) begin
          chk(scnt >= int'(settle_i) + 1, "R5", "settle cycles", scnt, int'(settle_i) + 1);
          chk(lat == 0, "R6", "start while pending", lat, 0);
          chk(busy_o == 1'b1, "R10", "start only when busy", int'(busy_o), 1);
          if (exp_pos < exp_n) begin
            e = exp_idx[exp_pos];
            chk(int'(mux_addr_o) == e, m_diode[e] ? "R3" : "R2", "sensor order", int'(mux_addr_o), e);
            chk(src_sel_o == m_diode[e], "R4", "source select", int'(src_sel_o), int'(m_diode[e]));
            chk(cur_lvl_o == m_lvl[e] && gain_o == m_gain[e], "R4", "level/gain",
                int'({cur_lvl_o, gain_o}), int'({m_lvl[e], m_gain[e]}));
          end else begin
            chk(1'b0, "R9", "extra conversion", exp_pos, exp_n);
          end
          exp_pos++;
          cur = int'(mux_addr_o);
          conv_seq++;
          val = f_val(conv_seq, cur, int'(cur_lvl_o), int'(gain_o));
          lat = 1 + int'($urandom % 4);
        end else if (lat > 0) begin
          lat--;
          if (lat == 0) begin
            chk(int'(mux_addr_o) == cur, "R4", "mux stable until done", int'(mux_addr_o), cur);
            adc_done_i = 1'b1;
            adc_data_i = val;
            done_prev = 1'b1;
            m_res[cur] = val;
            if (!m_diode[cur]) begin
              upd_exp = 1'b1; upd_idx_e = cur; upd_data_e = val;
            end
          end
        end
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd20714);
    for (int k = 0; k < N; k++) begin
      m_diode[k] = 1'b0; m_lvl[k] = '0; m_gain[k] = '0; m_res[k] = '0;
    end
    repeat (3) @(negedge clk);
    chk(!busy_o && !adc_start_o && !upd_valid_o && !hk_valid_o && !overrun_o && mux_addr_o == '0,
        "R1", "reset outputs", int'({busy_o, adc_start_o, upd_valid_o, hk_valid_o, overrun_o}), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // random mix, ~40% diodes; runs into the tenth-cycle snapshot
    cfg_random(40);
    for (int c = 0; c < 10; c++) run_cycle(1'b0);

    // no diodes at all: pointer must not move
    for (int k = 0; k < N; k++) cfg_wr(k, 1'b0, k % 6, k % 4);
    run_cycle(1'b0);

    // only diodes: exactly K per cycle, wrap across the end of the table
    for (int k = 0; k < N; k++) cfg_wr(k, 1'b1, (k + 2) % 6, (k + 1) % 4);
    run_cycle(1'b0);
    run_cycle(1'b0);

    // a single diode: read once per cycle
    for (int k = 0; k < N; k++) cfg_wr(k, (k == 44), 5, 3);
    run_cycle(1'b0);
    run_cycle(1'b0);

    // settle extremes
    cfg_random(40);
    settle_i = 8'd0;
    run_cycle(1'b0);
    settle_i = 8'd12;
    run_cycle(1'b0);
    settle_i = 8'd4;

    // overrun: second tick mid-cycle is dropped and flagged
    chk(overrun_o == 1'b0, "R9", "overrun clear before", int'(overrun_o), 0);
    run_cycle(1'b1);
    chk(overrun_o == 1'b1, "R9", "overrun set", int'(overrun_o), 1);

    // more random traffic through the second snapshot
    for (int c = 0; c < 5; c++) begin
      cfg_random(30 + c * 10);
      run_cycle(1'b0);
    end
    chk(overrun_o == 1'b1, "R9", "overrun sticky", int'(overrun_o), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule